// File: doc/BRIEF.md
# Shift-and-Store Register

This block is a serial-to-parallel converter with a held output stage. Bits arrive one at a time on a serial input and advance one position per rising edge of the shift clock through a chain of stages. A separate storage stage, opened by a strobe, copies the chain so that the parallel outputs show a stable word while new data is shifted in behind it. A bus enable either drives the stored word onto the parallel pins or releases them to high impedance, so several blocks can share one bus.

Two serial cascade outputs carry the bit leaving the last stage so that blocks can be chained into longer registers. One follows the last stage directly and changes on the rising edge. The other re-times the same bit to the following falling edge, which gives the next block in a chain half a clock of hold margin when its clock arrives late.

Top module: `shift_store_reg`

## Requirements
- R1: While the active-low asynchronous reset is held, the shift stages, the storage stage and both cascade outputs read 0; with the bus enable high the parallel outputs read all zeros.
- R2: On each rising shift-clock edge, stage 0 loads the serial input and every stage k above 0 loads the previous value of stage k-1. Parallel output bit k shows stage k, so the first bit shifted in appears on bit 7 after eight edges.
- R3: The rising-edge cascade output equals the last stage (stage 7) and changes only at rising shift-clock edges.
- R4: The falling-edge cascade output takes the last stage's value at each falling shift-clock edge. Between a rising edge and the next falling edge it still shows the bit that the last stage held before that rising edge.
- R5: While the strobe is high, the storage stage is transparent and follows the shift stages, including changes made at rising edges during that time.
- R6: While the strobe is low, the storage stage holds the value it had when the strobe fell, and shifting does not change the parallel outputs.
- R7: With the bus enable low, all parallel outputs are high impedance; with it high, they drive the storage stage. The cascade outputs do not depend on the bus enable.
- R8: When the falling-edge cascade output of one block feeds the serial input of a second block on the same clock, the pair acts as a 16-stage register: after 16 rising edges the word sent most significant bit first lies across the second block's outputs (high byte) and the first block's outputs (low byte).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shiftClk | input | 1 | Shift clock; stages move on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| serIn | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High makes the storage stage transparent, low holds it |
| outEn | input | 1 | High drives the parallel outputs, low releases them |
| parOut | output | 8 | Tri-state parallel outputs, bit k from stored stage k |
| casRise | output | 1 | Cascade bit from the last stage, rising-edge timed |
| casFall | output | 1 | Same cascade bit, re-timed to the falling edge |

## Verification
Stage contents and the rising-edge cascade bit are due at the rising edge that takes the input, so the bench drives inputs two nanoseconds after that edge and compares one nanosecond later, well before the falling edge. The falling-edge cascade bit is compared twice per cycle: after the rising edge it must still show the old bit, and one nanosecond after the falling edge it must show the new one. The storage stage is transparent with no clock, so a strobe change is compared one nanosecond after it is driven, and a behavioural model of both chained blocks is compared at every one of these points.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic latchOpen;  // storage stage transparent
    logic driveBus;   // parallel pins driven
  } ssr_ctrl_t;

endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic       strobe,
  input  logic       outEn,
  output ssr_ctrl_t  ctrlOut
);

  always_comb begin
    ctrlOut.latchOpen = strobe;
    ctrlOut.driveBus  = outEn;
  end

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              shiftClk,
  input  logic              rstN,
  input  logic              serIn,
  input  ssr_ctrl_t         ctrlIn,
  output wire  [STAGES-1:0] parOut,
  output logic              casRise,
  output logic              casFall
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] shiftQ;
  logic [STAGES-1:0] storeQ;
  logic              fallQ;

  // Shift chain: one flop per stage, stage 0 fed from the serial input.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic nextBit;
    if (i == 0) begin : g_head
      assign nextBit = serIn;
    end else begin : g_body
      assign nextBit = shiftQ[i-1];
    end
    always_ff @(posedge shiftClk or negedge rstN) begin
      if (!rstN) shiftQ[i] <= 1'b0;
      else       shiftQ[i] <= nextBit;
    end
  end

  // Storage stage: transparent while the strobe is high.
  always_latch begin
    if (!rstN)                 storeQ <= '0;
    else if (ctrlIn.latchOpen) storeQ <= shiftQ;
  end

  // Falling-edge re-timing of the last stage.
  always_ff @(negedge shiftClk or negedge rstN) begin
    if (!rstN) fallQ <= 1'b0;
    else       fallQ <= shiftQ[LAST];
  end

  assign casRise = shiftQ[LAST];
  assign casFall = fallQ;
  assign parOut  = ctrlIn.driveBus ? storeQ : {STAGES{1'bz}};

  // R2: stage 0 captured the serial input at the previous edge
  p_head_load_r2: assert property (@(posedge shiftClk) disable iff (!rstN)
    $past(rstN) |-> (shiftQ[0] == $past(serIn)));

  // R2: every stage above 0 took its neighbour's old value
  p_chain_move_r2: assert property (@(posedge shiftClk) disable iff (!rstN)
    $past(rstN) |-> (shiftQ[LAST:1] == $past(shiftQ[LAST-1:0])));

  // R4: the re-timed bit has caught up with the last stage by the rising edge
  p_fall_lag_r4: assert property (@(posedge shiftClk) disable iff (!rstN)
    $past(rstN) |-> (fallQ == shiftQ[LAST]));

  // R5: an open storage stage mirrors the chain
  p_store_follow_r5: assert property (@(posedge shiftClk) disable iff (!rstN)
    ctrlIn.latchOpen |-> (storeQ == shiftQ));

  // R6: a closed storage stage keeps its word across edges
  p_store_hold_r6: assert property (@(posedge shiftClk) disable iff (!rstN)
    ($past(rstN) && !ctrlIn.latchOpen && !$past(ctrlIn.latchOpen)) |-> $stable(storeQ));

endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
  import ssr_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              shiftClk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              strobe,
  input  logic              outEn,
  output wire  [STAGES-1:0] parOut,
  output logic              casRise,
  output logic              casFall
);

  ssr_ctrl_t ctrlBus;

  ssr_ctrl u_ctrl (
    .strobe  (strobe),
    .outEn   (outEn),
    .ctrlOut (ctrlBus)
  );

  ssr_datapath #(.STAGES(STAGES)) u_dp (
    .shiftClk (shiftClk),
    .rstN     (rstN),
    .serIn    (serIn),
    .ctrlIn   (ctrlBus),
    .parOut   (parOut),
    .casRise  (casRise),
    .casFall  (casFall)
  );

endmodule

// File: tb/shift_store_reg_bench.sv
module shift_store_reg_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic strobe = 1'b0;
  logic outEn = 1'b0;

  wire [7:0] busA;
  wire [7:0] busB;
  logic riseA, fallA, riseB, fallB;

  // Bench keeper drives a marker value whenever the blocks release the bus.
  assign busA = outEn ? 8'bz : 8'h5A;
  assign busB = outEn ? 8'bz : 8'h5A;

  always #5 clk = ~clk;

  shift_store_reg u_shift_store_reg (
    .shiftClk (clk), .rstN (rstN), .serIn (serIn), .strobe (strobe),
    .outEn (outEn), .parOut (busA), .casRise (riseA), .casFall (fallA)
  );

  shift_store_reg u_shift_store_reg_b (
    .shiftClk (clk), .rstN (rstN), .serIn (fallA), .strobe (strobe),
    .outEn (outEn), .parOut (busB), .casRise (riseB), .casFall (fallB)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  bit [7:0] mShA, mShB, mStA, mStB;
  bit       mFaA, mFaB;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string phase);
    logic [7:0] expA, expB;
    string busReq;
    expA = outEn ? mStA : 8'h5A;
    expB = outEn ? mStB : 8'h5A;
    busReq = !outEn ? "R7" : (strobe ? "R5" : "R6");
    chk(busA === expA, busReq, {"busA ", phase}, {8'h0, busA}, {8'h0, expA});
    chk(busB === expB, busReq, {"busB ", phase}, {8'h0, busB}, {8'h0, expB});
    chk(riseA === mShA[7], "R3", {"riseA ", phase}, {15'h0, riseA}, {15'h0, mShA[7]});
    chk(riseB === mShB[7], "R3", {"riseB ", phase}, {15'h0, riseB}, {15'h0, mShB[7]});
    chk(fallA === mFaA, "R4", {"fallA ", phase}, {15'h0, fallA}, {15'h0, mFaA});
    chk(fallB === mFaB, "R4", {"fallB ", phase}, {15'h0, fallB}, {15'h0, mFaB});
  endtask

  // One shift-clock cycle, entered and left at rising edge + 2 ns.
  task automatic tick(input bit din, input bit st, input bit oe);
    serIn = din; strobe = st; outEn = oe;
    #1;
    if (st) begin mStA = mShA; mStB = mShB; end
    compareAll("after rise");
    @(negedge clk); #1;
    mFaA = mShA[7]; mFaB = mShB[7];
    compareAll("after fall");
    @(posedge clk);
    mShB = {mShB[6:0], mFaA};
    mShA = {mShA[6:0], din};
    if (st) begin mStA = mShA; mStB = mShB; end
    #2;
  endtask

  initial begin
    logic [7:0] held;
    logic [15:0] word;
    logic [15:0] lfsr;
    mShA = '0; mShB = '0; mStA = '0; mStB = '0; mFaA = 1'b0; mFaB = 1'b0;

    // R1: reset state with the bus driven
    rstN = 1'b0; strobe = 1'b1; outEn = 1'b1; serIn = 1'b1;
    @(posedge clk); #2;
    chk(busA === 8'h00, "R1", "busA in reset", {8'h0, busA}, 16'h0);
    chk({riseA, fallA, riseB, fallB} === 4'b0, "R1", "cascades in reset",
        {12'h0, riseA, fallA, riseB, fallB}, 16'h0);
    rstN = 1'b1;

    // R2/R5: walk one pattern through with the storage stage open
    for (int i = 7; i >= 0; i--) tick(8'hB4 >> i, 1'b1, 1'b1);
    chk(busA === 8'hB4, "R2", "pattern after 8 edges", {8'h0, busA}, 16'h00B4);

    // R6: close storage, shift a new pattern, bus must stay put
    held = busA;
    for (int i = 7; i >= 0; i--) tick(8'h3C >> i, 1'b0, 1'b1);
    chk(busA === held, "R6", "held word during shifting", {8'h0, busA}, {8'h0, held});

    // R5: reopen, storage catches up at once
    tick(1'b0, 1'b1, 1'b1);

    // R7: release the bus while shifting; cascades keep going
    for (int i = 0; i < 6; i++) tick(i[0], 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b1);

    // R8: 16-bit word across the chained pair, MSB first
    word = 16'hA5C3;
    for (int i = 15; i >= 0; i--) tick(word[i], 1'b1, 1'b1);
    chk({busB, busA} === word, "R8", "chained word", {busB, busA}, word);

    // Mixed traffic from a bench LFSR
    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0], lfsr[3] | lfsr[5], lfsr[7] | lfsr[9]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule